// File: doc/BRIEF.md
# T1 Facility Data Link Source Multiplexer

This block decides which bit goes into each data link slot of an outgoing T1 frame stream. A framer timing counter supplies a strobe for every framing bit position and the index of the current frame in the superframe. From these the block finds the data link slots. In extended superframe (ESF) mode these are the facility data link bits. In D4 mode they are the Fs bits. For each slot the block emits one bit and a valid strobe one cycle later.

Three sources can be chosen for the data link:
- a repeating bit-oriented message: a run of eight ones followed by an 8-bit code word;
- an internal bit-serial HDLC transmitter;
- an external serial data input.

If no source is enabled, the block sends all ones. The block samples the source selection and the framing mode only at superframe boundaries, so a sequence is never split part way through a superframe. It also drives a data link timing output. This output is either a gapped clock or an active-low enable, and it is aligned with the valid strobe.

Top module: `fdl_src_mux`

## Requirements
- R1: A data link slot is a cycle with `fbit_strobe` high where either (a) the latched mode is ESF and `frame_idx` is even and below 24, or (b) the latched mode is D4 and `frame_idx` is odd and below 12. In the cycle after a slot, `dl_valid` is 1 and `dl_bit` carries the chosen bit. In every other cycle `dl_valid` is 0 and `dl_bit` is 1.
- R2: With the message source selected, successive slots carry a 16-bit pattern that repeats across superframes without a break. The pattern is eight 1 bits, then the code word with the most significant bit first. The pattern begins at its first bit on the first slot after the message source becomes selected.
- R3: The code word `bom_word` is captured at the first bit of each 16-bit pattern. A change made part way through a pattern shows up only in the next pattern.
- R4: `idle_warn` is 1 exactly while `bom_word` equals 0x7E, whatever the enables are.
- R5: With the external source selected, `ext_take` is high in each slot cycle. `ext_din` is sampled in that cycle and sent. This works in both ESF and D4 mode.
- R6: With the HDLC source selected, `hdlc_take` is high in each slot cycle and `hdlc_txd` is sampled and sent. `ext_take` stays low and `ext_din` has no effect on `dl_bit`.
- R7: The source is chosen in this order of priority: message (ESF and `bom_en`), then HDLC (ESF, `hdlc_en` and `hdlc_payload_sel` = 0), then external (`ext_en`). If none of these applies, all ones are sent and neither take strobe rises.
- R8: The mode and source selection are sampled only on a strobe with `frame_idx` = 0, and that slot already uses the new values. Control changes made at any other time have no effect until the next such strobe. After reset the block behaves as ESF with all ones.
- R9: With `dl_gap_mode` = 1, `dl_clk` is high only in cycles where `dl_valid` is high. With `dl_gap_mode` = 0, `dl_clk` is low exactly in those cycles.
- R10: While reset is held, `dl_valid` is 0 and `dl_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbit_strobe | input | 1 | Framing bit position of the current frame |
| frame_idx | input | 5 | Frame index within the superframe, starting at 0 |
| esf_mode | input | 1 | 1 = ESF, 0 = D4 |
| bom_en | input | 1 | Enable the bit-oriented message source |
| bom_word | input | 8 | Message code word |
| hdlc_en | input | 1 | Enable the internal HDLC source |
| hdlc_payload_sel | input | 1 | HDLC is attached to a payload timeslot, not the data link |
| ext_en | input | 1 | Enable the external serial source |
| ext_din | input | 1 | External serial data |
| hdlc_txd | input | 1 | HDLC transmit bit |
| dl_gap_mode | input | 1 | 1 = gapped clock, 0 = active-low enable |
| dl_bit | output | 1 | Data link bit |
| dl_valid | output | 1 | `dl_bit` holds a slot's bit |
| dl_clk | output | 1 | Gapped clock or active-low enable |
| ext_take | output | 1 | External bit consumed this cycle |
| hdlc_take | output | 1 | HDLC bit consumed this cycle |
| idle_warn | output | 1 | The code word looks like the idle flag |

## Verification
Two functions can fall in the same cycle: a control change and a superframe-boundary slot. The frame-0 slot applies the new selection and also sends a bit. When the message source is selected, the same slot can also open a new 16-bit pattern that captures the code word. The random phase toggles enables, mode and the code word in arbitrary cycles, including exactly on the boundary strobe. A behavioural model picks the source only on that strobe and keeps its own pattern position. Every output is compared with this model on every cycle.

// File: rtl/fdl_mux_pkg.sv
package fdl_mux_pkg;
  localparam int FRAME_W    = 5;
  localparam int ESF_FRAMES = 24;
  localparam int D4_FRAMES  = 12;

  typedef enum logic [1:0] {
    SRC_ONES = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_HDLC = 2'd2,
    SRC_BOM  = 2'd3
  } fdl_src_e;

  // ESF: even index (odd frame number); D4: odd index (even frame number)
  function automatic logic is_dl_slot(input logic esf, input logic [FRAME_W-1:0] idx);
    if (esf) return (idx < FRAME_W'(ESF_FRAMES)) && !idx[0];
    else     return (idx < FRAME_W'(D4_FRAMES)) && idx[0];
  endfunction

  function automatic fdl_src_e pick_src(input logic esf, input logic bom_en,
                                        input logic hdlc_en, input logic payload,
                                        input logic ext_en);
    if (esf && bom_en)                  return SRC_BOM;
    else if (esf && hdlc_en && !payload) return SRC_HDLC;
    else if (ext_en)                    return SRC_EXT;
    else                                return SRC_ONES;
  endfunction
endpackage

// File: rtl/fdl_sel_latch.sv
module fdl_sel_latch
  import fdl_mux_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sf_start,
  input  logic     esf_in,
  input  logic     bom_en,
  input  logic     hdlc_en,
  input  logic     hdlc_payload,
  input  logic     ext_en,
  output logic     eff_esf,
  output fdl_src_e eff_src
);
  logic     esf_q;
  fdl_src_e src_q;
  fdl_src_e src_new;

  always_comb src_new = pick_src(esf_in, bom_en, hdlc_en, hdlc_payload, ext_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esf_q <= 1'b1;
      src_q <= SRC_ONES;
    end else if (sf_start) begin
      esf_q <= esf_in;
      src_q <= src_new;
    end
  end

  // The boundary slot already uses the fresh selection
  always_comb begin
    eff_esf = sf_start ? esf_in  : esf_q;
    eff_src = sf_start ? src_new : src_q;
  end
endmodule

// File: rtl/fdl_bom_gen.sv
module fdl_bom_gen #(
  parameter int MSG_W    = 8,
  parameter int ONES_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             advance,
  input  logic [MSG_W-1:0] word,
  output logic             pat_bit
);
  localparam int PAT_LEN = ONES_LEN + MSG_W;
  localparam int POS_W   = $clog2(PAT_LEN);

  logic [POS_W-1:0] pos;
  logic [MSG_W-1:0] word_q;
  logic [MSG_W-1:0] shifted;
  logic             pat_start;

  assign pat_start = advance && (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      word_q <= '0;
    end else if (!sel) begin
      pos <= '0;
    end else if (advance) begin
      if (pat_start) word_q <= word;
      pos <= (pos == POS_W'(PAT_LEN - 1)) ? '0 : pos + 1'b1;
    end
  end

  always_comb begin
    shifted = word_q << (pos - POS_W'(ONES_LEN));
    pat_bit = (pos < POS_W'(ONES_LEN)) ? 1'b1 : shifted[MSG_W-1];
  end

  // R3
  word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && pat_start) |=> (word_q == $past(word)));
endmodule

// File: rtl/fdl_src_mux.sv
module fdl_src_mux
  import fdl_mux_pkg::*;
#(
  parameter int          MSG_W     = 8,
  parameter int          ONES_LEN  = 8,
  parameter logic [MSG_W-1:0] IDLE_CODE = 8'h7E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fbit_strobe,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               esf_mode,
  input  logic               bom_en,
  input  logic [MSG_W-1:0]   bom_word,
  input  logic               hdlc_en,
  input  logic               hdlc_payload_sel,
  input  logic               ext_en,
  input  logic               ext_din,
  input  logic               hdlc_txd,
  input  logic               dl_gap_mode,
  output logic               dl_bit,
  output logic               dl_valid,
  output logic               dl_clk,
  output logic               ext_take,
  output logic               hdlc_take,
  output logic               idle_warn
);
  logic     sf_start;
  logic     eff_esf;
  fdl_src_e eff_src;
  logic     slot;
  logic     bom_sel;
  logic     bom_bit;
  logic     next_bit;

  assign sf_start = fbit_strobe && (frame_idx == '0);

  fdl_sel_latch u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .sf_start     (sf_start),
    .esf_in       (esf_mode),
    .bom_en       (bom_en),
    .hdlc_en      (hdlc_en),
    .hdlc_payload (hdlc_payload_sel),
    .ext_en       (ext_en),
    .eff_esf      (eff_esf),
    .eff_src      (eff_src)
  );

  assign slot    = fbit_strobe && is_dl_slot(eff_esf, frame_idx);
  assign bom_sel = (eff_src == SRC_BOM);

  fdl_bom_gen #(.MSG_W(MSG_W), .ONES_LEN(ONES_LEN)) u_bom (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bom_sel),
    .advance (slot && bom_sel),
    .word    (bom_word),
    .pat_bit (bom_bit)
  );

  assign ext_take  = slot && (eff_src == SRC_EXT);
  assign hdlc_take = slot && (eff_src == SRC_HDLC);

  always_comb begin
    unique case (eff_src)
      SRC_BOM:  next_bit = bom_bit;
      SRC_HDLC: next_bit = hdlc_txd;
      SRC_EXT:  next_bit = ext_din;
      default:  next_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_valid <= 1'b0;
      dl_bit   <= 1'b1;
    end else begin
      dl_valid <= slot;
      dl_bit   <= slot ? next_bit : 1'b1;
    end
  end

  assign dl_clk    = dl_gap_mode ? dl_valid : !dl_valid;
  assign idle_warn = (bom_word == IDLE_CODE);

  // R1
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> $past(fbit_strobe));
  // R7
  takes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_take && hdlc_take));
  // R6
  hdlc_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && hdlc_take) |=> (dl_valid && dl_bit == $past(hdlc_txd)));
  // R5
  ext_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ext_take) |=> (dl_valid && dl_bit == $past(ext_din)));
  // R7
  d4_no_hdlc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_esf |-> !hdlc_take);
endmodule

// File: tb/tb_fdl_src_mux.sv
module tb_fdl_src_mux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fbit_strobe;
  logic [4:0] frame_idx;
  logic       esf_mode, bom_en, hdlc_en, hdlc_payload_sel, ext_en;
  logic [7:0] bom_word;
  logic       ext_din, hdlc_txd, dl_gap_mode;
  logic       dl_bit, dl_valid, dl_clk, ext_take, hdlc_take, idle_warn;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdl_src_mux dut (
    .clk(clk), .rst_n(rst_n), .fbit_strobe(fbit_strobe), .frame_idx(frame_idx),
    .esf_mode(esf_mode), .bom_en(bom_en), .bom_word(bom_word), .hdlc_en(hdlc_en),
    .hdlc_payload_sel(hdlc_payload_sel), .ext_en(ext_en), .ext_din(ext_din),
    .hdlc_txd(hdlc_txd), .dl_gap_mode(dl_gap_mode), .dl_bit(dl_bit),
    .dl_valid(dl_valid), .dl_clk(dl_clk), .ext_take(ext_take),
    .hdlc_take(hdlc_take), .idle_warn(idle_warn)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Behavioural reference state
  int m_src   = 0;   // 0 ones, 1 ext, 2 hdlc, 3 message
  int m_esf   = 1;
  int m_pos   = 0;
  int m_word  = 0;
  int e_valid = 0;
  int e_bit   = 1;
  int e_src   = 0;
  int phase   = 0;
  int fcount  = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string bit_tag(input int s);
    case (s)
      3: return "R2 message bit";
      2: return "R6 hdlc bit";
      1: return "R5 external bit";
      default: return "R7 all-ones bit";
    endcase
  endfunction

  task automatic step(input bit rnd);
    int sel_now, want_slot, b, lim;
    @(negedge clk);
    chk("R1 dl_valid", dl_valid, e_valid);
    chk(e_valid ? bit_tag(e_src) : "R1 idle dl_bit", dl_bit, e_bit);
    // R8: random control flips land on any cycle, boundary included
    if (rnd) begin
      if ($urandom_range(0, 29) == 0) esf_mode = ~esf_mode;
      if ($urandom_range(0, 19) == 0) bom_en = ~bom_en;
      if ($urandom_range(0, 19) == 0) hdlc_en = ~hdlc_en;
      if ($urandom_range(0, 19) == 0) hdlc_payload_sel = ~hdlc_payload_sel;
      if ($urandom_range(0, 19) == 0) ext_en = ~ext_en;
      if ($urandom_range(0, 39) == 0) dl_gap_mode = ~dl_gap_mode;
      // R3: word changes inside a pattern
      if ($urandom_range(0, 24) == 0) bom_word = 8'($urandom);
    end
    ext_din  = 1'($urandom);
    hdlc_txd = 1'($urandom);
    fbit_strobe = (phase == 0);
    frame_idx   = 5'(fcount);
    #1;
    // model of this cycle
    if (fbit_strobe && fcount == 0) begin
      m_esf = esf_mode;
      if (m_esf && bom_en) m_src = 3;
      else if (m_esf && hdlc_en && !hdlc_payload_sel) m_src = 2;
      else if (ext_en) m_src = 1;
      else m_src = 0;
    end
    if (m_src != 3) m_pos = 0;
    want_slot = 0;
    if (fbit_strobe) begin
      if (m_esf != 0) want_slot = (fcount < 24) && (fcount % 2 == 0);
      else            want_slot = (fcount < 12) && (fcount % 2 == 1);
    end
    sel_now = m_src;
    chk("R5 ext_take", ext_take, want_slot && sel_now == 1);
    chk("R6 hdlc_take", hdlc_take, want_slot && sel_now == 2);
    chk("R4 idle_warn", idle_warn, bom_word == 8'h7E);
    chk("R9 dl_clk", dl_clk, dl_gap_mode ? e_valid : !e_valid);
    b = 1;
    if (want_slot) begin
      case (sel_now)
        1: b = ext_din;
        2: b = hdlc_txd;
        3: begin
          if (m_pos == 0) m_word = bom_word;
          b = (m_pos < 8) ? 1 : ((m_word >> (15 - m_pos)) & 1);
          m_pos = (m_pos + 1) % 16;
        end
        default: b = 1;
      endcase
    end
    e_valid = want_slot;
    e_bit   = want_slot ? b : 1;
    e_src   = sel_now;
    // timing generator: strobe every fourth cycle
    if (fbit_strobe) begin
      lim = esf_mode ? 24 : 12;
      fcount = fcount + 1;
      if (fcount >= lim) fcount = 0;
    end
    phase = (phase + 1) % 4;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) step(rnd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fbit_strobe = 1'b0; frame_idx = '0; esf_mode = 1'b1;
    bom_en = 1'b0; bom_word = 8'h00; hdlc_en = 1'b0; hdlc_payload_sel = 1'b0;
    ext_en = 1'b0; ext_din = 1'b0; hdlc_txd = 1'b0; dl_gap_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset dl_valid", dl_valid, 0);
    chk("R10 reset dl_bit", dl_bit, 1);
    rst_n = 1'b1;
    // R8: all ones in ESF after reset
    run(200, 0);
    ext_en = 1'b1;                    // R5 in ESF
    run(300, 0);
    esf_mode = 1'b0; dl_gap_mode = 1'b0; // R5 in D4, R9 enable form
    run(300, 0);
    esf_mode = 1'b1; hdlc_en = 1'b1; // R6 beats external
    run(300, 0);
    hdlc_payload_sel = 1'b1;          // R7 falls back to external
    run(250, 0);
    hdlc_payload_sel = 1'b0; bom_en = 1'b1; bom_word = 8'h12; // R7 message wins
    run(250, 0);
    bom_word = 8'h5A;                 // R3 mid-pattern change
    run(400, 0);
    bom_word = 8'h7E;                 // R4
    run(100, 0);
    esf_mode = 1'b0;                  // R7: D4 drops message and hdlc
    run(250, 0);
    esf_mode = 1'b1; bom_en = 1'b0; hdlc_en = 1'b0; ext_en = 1'b0; dl_gap_mode = 1'b1;
    run(200, 0);
    run(8000, 1);                     // R8 random control timing
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule